// File: doc/BRIEF.md
# Processor Status Flag Update Unit

This block holds the four arithmetic status flags of a 32-bit processor (carry, overflow, zero, negative) and rewrites them from the outcome of each executed operation. The execution units compute the arithmetic themselves. They hand this block an operation class, the result word, and three side bits: carry or borrow out of the most significant bit, overflow, and the last bit shifted out. On a strobed operation the block decides which flags that class may touch. It writes those flags on the next clock edge.

The operation class sets the update policy. Integer add, integer subtract and the address-unit move write all four flags. A shift or rotate takes its carry from the bit shifted out. A floating-point operation that produces a fixed-point result keeps carry and writes the other three flags. A floating-point operation that produces a float result keeps both carry and overflow. A plain data transfer leaves every flag as it was. The zero test is built as a parameterised reduction tree, so the result width can change without rework.

Top module: `ccr_update`

## Requirements
- R1: While rst_ni is low, and on the first clock after it goes high with no operation strobed, flags_o is 4'b0000.
- R2: flags_o bit positions are [0]=carry, [1]=overflow, [2]=zero, [3]=negative. When op_valid_i is low on a rising clock edge, all four flags keep their values whatever the other inputs are.
- R3: For integer add (op_class_i=0) and integer subtract (op_class_i=1), carry takes carry_i (carry or borrow out of the MSB) and overflow takes ovf_i.
- R4: For shift or rotate (op_class_i=2), carry takes shift_out_i and overflow takes ovf_i.
- R5: For a floating-point operation with a fixed-point result (op_class_i=3), carry is held and overflow takes ovf_i.
- R6: For a floating-point operation with a float result (op_class_i=4), carry and overflow are both held.
- R7: For the address-unit move (op_class_i=5), carry takes carry_i and overflow takes ovf_i.
- R8: For op_class_i 0 to 5, zero is set exactly when every bit of result_i is 0, and negative takes result_i[31].
- R9: For a plain data transfer (op_class_i=6) and the unused code (op_class_i=7), all four flags are held.
- R10: A strobed operation is sampled on a rising edge of clk_i, and its flags appear on flags_o right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe; the flags update only when this is high |
| op_class_i | input | 3 | Operation class code, 0 to 7 |
| result_i | input | 32 | Result word of the operation |
| carry_i | input | 1 | Carry out of the MSB (add) or borrow out of the MSB (subtract, address move) |
| ovf_i | input | 1 | Result does not fit the destination width |
| shift_out_i | input | 1 | Last bit shifted out by a shift or rotate |
| flags_o | output | 4 | Status flags {negative, zero, overflow, carry} |

## Verification
The bench builds the block with its default 32-bit result width and an 8-bit leaf width for the zero-detect tree. That gives four leaves, so a single set bit in any leaf, and the sign bit alone, are both within reach of the zero and negative checks. Random results are biased toward all-zero and single-bit words. All eight class codes and idle cycles are mixed, which exercises every hold-versus-write combination of carry and overflow against a flag state that a previous operation left nonzero.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_INT_ADD   = 3'd0,
    OP_INT_SUB   = 3'd1,
    OP_SHIFT_ROT = 3'd2,
    OP_FP_FIX    = 3'd3,
    OP_FP_FLT    = 3'd4,
    OP_ADDR_MOVE = 3'd5,
    OP_DATA_XFER = 3'd6,
    OP_RESERVED  = 3'd7
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    logic c_we;
    logic v_we;
    logic zn_we;
  } flag_we_t;
endpackage

// File: rtl/ccr_zero_detect.sv
module ccr_zero_detect #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEAF_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              zero_o
);
  localparam int unsigned N_LEAF = (DATA_W + LEAF_W - 1) / LEAF_W;
  localparam int unsigned PAD_W  = N_LEAF * LEAF_W;

  logic [PAD_W-1:0]  data_pad;
  logic [N_LEAF-1:0] leaf_any;

  assign data_pad = PAD_W'(data_i);

  for (genvar g = 0; g < N_LEAF; g++) begin : g_leaf
    assign leaf_any[g] = |data_pad[g*LEAF_W +: LEAF_W];
  end

  assign zero_o = ~|leaf_any;
endmodule

// File: rtl/ccr_flag_eval.sv
module ccr_flag_eval
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEAF_W = 8
) (
  input  op_class_e         op_class_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              shift_out_i,
  output flags_t            flags_nxt_o,
  output flag_we_t          we_o
);
  logic res_zero;

  ccr_zero_detect #(
    .DATA_W(DATA_W),
    .LEAF_W(LEAF_W)
  ) i_zero (
    .data_i(result_i),
    .zero_o(res_zero)
  );

  always_comb begin
    flags_nxt_o.n = result_i[DATA_W-1];
    flags_nxt_o.z = res_zero;
    flags_nxt_o.v = ovf_i;
    flags_nxt_o.c = carry_i;
    we_o          = '0;
    unique case (op_class_i)
      OP_INT_ADD, OP_INT_SUB, OP_ADDR_MOVE: we_o = '{c_we: 1'b1, v_we: 1'b1, zn_we: 1'b1};
      OP_SHIFT_ROT: begin
        flags_nxt_o.c = shift_out_i;
        we_o          = '{c_we: 1'b1, v_we: 1'b1, zn_we: 1'b1};
      end
      OP_FP_FIX:    we_o = '{c_we: 1'b0, v_we: 1'b1, zn_we: 1'b1};
      OP_FP_FLT:    we_o = '{c_we: 1'b0, v_we: 1'b0, zn_we: 1'b1};
      OP_DATA_XFER, OP_RESERVED: we_o = '0;
      default:      we_o = '0;
    endcase
  end
endmodule

// File: rtl/ccr_update.sv
module ccr_update
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEAF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_class_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              shift_out_i,
  output logic [3:0]        flags_o
);
  flags_t   flags_q, flags_nxt;
  flag_we_t we;

  ccr_flag_eval #(
    .DATA_W(DATA_W),
    .LEAF_W(LEAF_W)
  ) i_eval (
    .op_class_i (op_class_e'(op_class_i)),
    .result_i   (result_i),
    .carry_i    (carry_i),
    .ovf_i      (ovf_i),
    .shift_out_i(shift_out_i),
    .flags_nxt_o(flags_nxt),
    .we_o       (we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (op_valid_i) begin
      if (we.c_we)  flags_q.c <= flags_nxt.c;
      if (we.v_we)  flags_q.v <= flags_nxt.v;
      if (we.zn_we) begin
        flags_q.z <= flags_nxt.z;
        flags_q.n <= flags_nxt.n;
      end
    end
  end

  assign flags_o = flags_q;

  always_comb begin
    if (!rst_ni) assert_reset_clear_R1: assert (flags_o == 4'b0000);
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(flags_o));

  assert_int_carry_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i inside {3'd0, 3'd1}) |=>
      (flags_o[0] == $past(carry_i) && flags_o[1] == $past(ovf_i)));

  assert_shift_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 3'd2) |=> flags_o[0] == $past(shift_out_i));

  assert_fp_fix_keeps_c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 3'd3) |=> ($stable(flags_o[0]) && flags_o[1] == $past(ovf_i)));

  assert_fp_flt_keeps_cv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 3'd4) |=> $stable(flags_o[1:0]));

  assert_addr_move_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 3'd5) |=>
      (flags_o[0] == $past(carry_i) && flags_o[1] == $past(ovf_i)));

  assert_zero_neg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i <= 3'd5) |=>
      (flags_o[2] == ($past(result_i) == '0) && flags_o[3] == $past(result_i[DATA_W-1])));

  assert_xfer_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i >= 3'd6) |=> $stable(flags_o));
endmodule

// File: tb/test_ccr_update.sv
`timescale 1ns/1ps
module test_ccr_update;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_class = 3'd0;
  logic [31:0] result = 32'd0;
  logic        carry = 1'b0, ovf = 1'b0, shift_out = 1'b0;
  logic [3:0]  flags;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [3:0] model = 4'b0;

  always #2 clk = ~clk;

  ccr_update i_ccr_update (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_class_i(op_class),
    .result_i(result), .carry_i(carry), .ovf_i(ovf), .shift_out_i(shift_out),
    .flags_o(flags)
  );

  function automatic logic [3:0] next_flags(logic [3:0] cur, logic vld, logic [2:0] cls,
                                            logic [31:0] res, logic ci, logic vi, logic si);
    logic [3:0] f = cur;
    if (!vld || cls >= 3'd6) return cur;
    f[2] = (res == 32'd0);
    f[3] = res[31];
    case (cls)
      3'd0, 3'd1, 3'd5: begin f[0] = ci; f[1] = vi; end
      3'd2: begin f[0] = si; f[1] = vi; end
      3'd3: f[1] = vi;
      default: ;
    endcase
    return f;
  endfunction

  function automatic string req_of(logic vld, logic [2:0] cls);
    if (!vld) return "R2";
    case (cls)
      3'd0, 3'd1: return "R3/R8";
      3'd2: return "R4/R8";
      3'd3: return "R5/R8";
      3'd4: return "R6/R8";
      3'd5: return "R7/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    n_chk++;
    if (flags !== exp) begin
      n_bad++;
      $display("FAIL %s: flags=%b expected=%b", req, flags, exp);
    end
  endtask

  // R10: drive at negedge, the flags show after the next rising edge
  task automatic apply(logic vld, logic [2:0] cls, logic [31:0] res, logic ci, logic vi, logic si);
    op_valid = vld; op_class = cls; result = res; carry = ci; ovf = vi; shift_out = si;
    model = next_flags(model, vld, cls, res, ci, vi, si);
    @(negedge clk);
    check({req_of(vld, cls), " R10"}, model);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: flags=%b expected=completion", flags);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    // R1: reset state with busy inputs
    op_class = 3'd0; result = 32'h8000_0001; carry = 1'b1; ovf = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 4'b0000);

    // directed corners
    apply(1, 3'd0, 32'h0000_0000, 1, 0, 0);    // add: carry out, zero result
    apply(1, 3'd1, 32'h8000_0000, 0, 1, 0);    // subtract: sign bit only, overflow
    apply(1, 3'd4, 32'h0000_0100, 1, 0, 1);    // float result: C and V held
    apply(1, 3'd3, 32'hFFFF_FFFF, 0, 0, 1);    // fixed result: C held, V cleared
    apply(1, 3'd2, 32'h0100_0000, 0, 1, 1);    // shift: C from shifted-out bit
    apply(1, 3'd6, 32'h0000_0000, 0, 0, 0);    // R9 transfer: all held
    apply(1, 3'd7, 32'h8000_0000, 1, 1, 1);    // R9 unused code
    apply(0, 3'd0, 32'h0000_0000, 0, 0, 0);    // R2 idle
    apply(1, 3'd5, 32'h0000_0001, 1, 1, 0);    // R7 address move
    apply(1, 3'd5, 32'h0000_0000, 0, 0, 1);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 4)
        0: r = 32'd0;
        1: r = 32'd1 << ($urandom % 32);
        default: r = $urandom;
      endcase
      apply(($urandom % 5) != 0, 3'($urandom % 8), r,
            1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule